// File: doc/BRIEF.md
# Shared External Bus Arbiter

This block decides which of several processors owns one shared external memory bus. Each processor raises its own request line. The arbiter answers with a one-hot, registered grant vector, the index of the owner, and a one-cycle flag that marks an ownership forced off by time-out. A configuration input selects the priority scheme. In fixed mode the lowest-numbered candidate wins. In rotating mode the search starts just after the most recent owner.

An owner that keeps requesting keeps the bus, and no higher-priority request takes it away. A lock input lets the owner hold the bus even after it lowers its request, for example across several transactions. A programmable time-out bounds either kind of hold. Once another processor has waited the programmed number of cycles, the grant is revoked, even under lock. When nobody else is requesting, the owner stays parked on the bus.

The controller is a three-state machine. `ST_IDLE` means no grant and nothing parked. `ST_OWN` means a grant is driven. `ST_GAP` is the single dead cycle after a revoke, in which the next owner is chosen. The transitions are:
- `IDLE->OWN` when any request is present.
- `OWN->GAP` on a release or a time-out.
- `GAP->OWN` when a candidate remains.
- `GAP->IDLE` when no request is left.

Top module: `xbus_arbiter`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `grant` is all zero, `owner` is 0 and `timeout_evt` is 0.
- R2: `grant` is never more than one-hot. From the no-grant state, a request sampled at a rising edge yields a grant at that same edge.
- R3: With `rotate_mode`=0 at a decision, the lowest-numbered candidate wins.
- R4: With `rotate_mode`=1 at a decision, the candidates are searched starting at (previous owner + 1) modulo 4, wrapping. Right after reset, the previous owner counts as 0.
- R5: An owner whose own request is still high is never revoked, except by time-out, whatever the priority of other requests.
- R6: With no request from any other processor, the owner keeps its grant (parks), even after its own request falls.
- R7: While `lock` is high, the owner is not revoked, except by time-out.
- R8: With `timeout_limit`=L>0, the grant is revoked at the edge that ends the L-th consecutive owned cycle in which another request was pending. If `timeout_limit`=0, no time-out occurs.
- R9: `timeout_evt` is high for exactly the cycle in which the grant first reads zero after a time-out revoke, and at no other time.
- R10: After a revoke, `grant` is zero for exactly one cycle before the next grant, if a request remains at that point. The grant never moves directly from one processor to another.
- R11: At the decision after a revoke, the revoked owner is excluded when any other processor is requesting.
- R12: `rotate_mode` is read only at decisions. Changing it during an ownership does not disturb the grant.
- R13: `owner` is the index of the granted processor, and it holds the last owner while no grant is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | N (4) | Request line from each processor |
| lock | input | 1 | Owner asks to keep the bus |
| rotate_mode | input | 1 | 0 = fixed priority, 1 = rotating priority |
| timeout_limit | input | TW (16) | Wait cycles before forced release; 0 disables |
| grant | output | N (4) | One-hot registered grant |
| owner | output | IW (2) | Index of the current or last owner |
| timeout_evt | output | 1 | One-cycle pulse on a forced release |

## Verification
The bench targets the following corner cases, each with the failure it would expose:
- Locked owner hit by a time-out: a design where lock masks the counter would keep the bus forever.
- Lock held after the owner drops its request: a design that ignores lock would hand the bus over early.
- Time-out in fixed mode with processor 0 as owner: without exclusion of the revoked owner, processor 0 would win straight back.
- Limit of exactly one, and limit of zero: an off-by-one counter would revoke a cycle late, and a zero limit wrongly treated as a count would revoke at once.
- Flip of the mode input mid-ownership and a direct hand-over between two processors: these must never alter a live grant, and the hand-over must never skip the dead cycle.

// File: rtl/arb_pkg.sv
package arb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_OWN  = 2'd1,
        ST_GAP  = 2'd2
    } arb_state_e;
endpackage

// File: rtl/arb_pick.sv
module arb_pick #(
    parameter int N  = 4,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [N-1:0]  excl,
    input  logic          rotate,
    input  logic [IW-1:0] base,
    output logic          found,
    output logic [IW-1:0] idx
);
    logic [N-1:0]   cand;
    logic [2*N-1:0] dbl;
    logic [IW-1:0]  fix_idx;
    logic [IW-1:0]  rot_idx;
    int             start;

    // drop the excluded requester only if someone else remains
    always_comb begin
        cand = ((req & ~excl) != '0) ? (req & ~excl) : req;
        found = |cand;
    end

    always_comb begin
        fix_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) fix_idx = IW'(i);
        end
    end

    always_comb begin
        dbl = {cand, cand};
        start = (int'(base) + 1) % N;
        rot_idx = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (dbl[start + k]) rot_idx = IW'((start + k) % N);
        end
    end

    assign idx = rotate ? rot_idx : fix_idx;
endmodule

// File: rtl/arb_timer.sv
module arb_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          pending,
    input  logic [TW-1:0] limit,
    output logic          fire
);
    logic [TW-1:0] wait_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_cnt <= '0;
        end else if (clear || !pending) begin
            wait_cnt <= '0;
        end else if (wait_cnt != '1) begin
            wait_cnt <= wait_cnt + 1'b1;
        end
    end

    assign fire = pending && (limit != '0) &&
                  (({1'b0, wait_cnt} + (TW+1)'(1)) >= {1'b0, limit});
endmodule

// File: rtl/xbus_arbiter.sv
module xbus_arbiter #(
    parameter int N  = 4,
    parameter int TW = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N-1:0]          req,
    input  logic                  lock,
    input  logic                  rotate_mode,
    input  logic [TW-1:0]         timeout_limit,
    output logic [N-1:0]          grant,
    output logic [$clog2(N)-1:0]  owner,
    output logic                  timeout_evt
);
    import arb_pkg::*;
    localparam int IW = $clog2(N);

    arb_state_e    state_q, state_d;
    logic [IW-1:0] owner_q, owner_d;
    logic [N-1:0]  own_mask;
    logic [N-1:0]  excl;
    logic          others_pend;
    logic          own_req;
    logic          pick_found;
    logic [IW-1:0] pick_idx;
    logic          to_fire;
    logic          evt_d;

    assign own_mask    = N'(1) << owner_q;
    assign others_pend = |(req & ~own_mask);
    assign own_req     = |(req & own_mask);
    assign excl        = (state_q == ST_GAP) ? own_mask : '0;

    arb_pick #(.N(N), .IW(IW)) u_pick (
        .req    (req),
        .excl   (excl),
        .rotate (rotate_mode),
        .base   (owner_q),
        .found  (pick_found),
        .idx    (pick_idx)
    );

    arb_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (state_q != ST_OWN),
        .pending (others_pend),
        .limit   (timeout_limit),
        .fire    (to_fire)
    );

    // next-state and decision logic
    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        evt_d   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (pick_found) begin
                    state_d = ST_OWN;
                    owner_d = pick_idx;
                end
            end
            ST_OWN: begin
                if (others_pend && (to_fire || (!own_req && !lock))) begin
                    state_d = ST_GAP;
                    evt_d   = to_fire;
                end
            end
            ST_GAP: begin
                if (pick_found) begin
                    state_d = ST_OWN;
                    owner_d = pick_idx;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            owner_q <= '0;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grant       <= '0;
            timeout_evt <= 1'b0;
        end else begin
            grant       <= (state_d == ST_OWN) ? (N'(1) << owner_d) : '0;
            timeout_evt <= evt_d;
        end
    end

    assign owner = owner_q;
endmodule

// File: rtl/xbus_arbiter_chk.sv
module xbus_arbiter_chk #(
    parameter int N  = 4,
    parameter int TW = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [N-1:0]         req,
    input logic                 lock,
    input logic [TW-1:0]        timeout_limit,
    input logic [N-1:0]         grant,
    input logic [$clog2(N)-1:0] owner,
    input logic                 timeout_evt
);
    // R2: never more than one grant
    a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R13: grant matches owner index
    a_r13_owner_match: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant) |-> (grant == (N'(1) << owner)));

    // R10: a new grant always follows a cycle without grant
    a_r10_dead_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        ((|grant) && !$stable(grant)) |-> ($past(grant) == '0));

    // R5: requesting owner keeps bus unless timed out
    a_r5_keep_req: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant & req) != '0) |=> ($stable(grant) || timeout_evt));

    // R7: locked owner keeps bus unless timed out
    a_r7_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((|grant) && lock) |=> ($stable(grant) || timeout_evt));

    // R9: flag marks the drop of a grant
    a_r9_evt_drop: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_evt |-> ((grant == '0) && ($past(grant) != '0)));

    // R8: zero limit never times out
    a_r8_zero_off: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(timeout_limit) == '0) |-> !timeout_evt);
endmodule

bind xbus_arbiter xbus_arbiter_chk #(.N(N), .TW(TW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req           (req),
    .lock          (lock),
    .timeout_limit (timeout_limit),
    .grant         (grant),
    .owner         (owner),
    .timeout_evt   (timeout_evt)
);

// File: tb/tb_xbus_arbiter.sv
module tb_xbus_arbiter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  req = '0;
    logic        lock = 1'b0;
    logic        rotate_mode = 1'b0;
    logic [15:0] timeout_limit = '0;
    logic [3:0]  grant;
    logic [1:0]  owner;
    logic        timeout_evt;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    string cur_tag = "R1";
    logic [3:0] prev_grant = '0;

    // reference model state: 0 idle, 1 owned, 2 gap
    int m_st = 0;
    int m_own = 0;
    int m_cnt = 0;
    bit m_evt = 1'b0;

    xbus_arbiter dut (
        .clk(clk), .rst_n(rst_n), .req(req), .lock(lock),
        .rotate_mode(rotate_mode), .timeout_limit(timeout_limit),
        .grant(grant), .owner(owner), .timeout_evt(timeout_evt)
    );

    always #4 clk = ~clk;

    function automatic int m_pick(logic [3:0] c, logic rot, int base);
        for (int k = 0; k < 4; k++) begin
            int i;
            i = rot ? (base + 1 + k) % 4 : k;
            if (c[i]) return i;
        end
        return 0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_own = 0; m_cnt = 0; m_evt = 1'b0;
        end else begin
            logic [3:0] mask, c;
            bit pend, fire;
            mask = 4'b0001 << m_own;
            pend = (req & ~mask) != 4'b0;
            fire = (m_st == 1) && pend && (timeout_limit != 0) &&
                   (m_cnt + 1 >= int'(timeout_limit));
            m_evt = 1'b0;
            if (m_st != 1 || !pend) m_cnt = 0;
            else if (m_cnt < 65535) m_cnt = m_cnt + 1;
            case (m_st)
                0: if (req != 0) begin m_own = m_pick(req, rotate_mode, m_own); m_st = 1; end
                1: if (pend && (fire || (!req[m_own] && !lock))) begin m_st = 2; m_evt = fire; end
                default: begin
                    c = req & ~mask;
                    if (c == 0) c = req;
                    if (c != 0) begin m_own = m_pick(c, rotate_mode, m_own); m_st = 1; end
                    else m_st = 0;
                end
            endcase
            if (m_st != 1) m_cnt = 0;
        end
    end

    task automatic chk(string tag, string what, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic cyc(int n);
        for (int j = 0; j < n; j++) begin
            @(negedge clk);
            chk(cur_tag, "grant", int'(grant), (m_st == 1) ? (1 << m_own) : 0);
            chk(cur_tag, "owner", int'(owner), m_own);
            chk(cur_tag, "timeout_evt", int'(timeout_evt), int'(m_evt));
            if (prev_grant != 0 && grant != 0 && grant != prev_grant)
                chk("R10", "direct handover", int'(grant), 0);
            prev_grant = grant;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: got %0d expected below 150000 cycles", cycles);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h5eed_0042);
        // R1: reset state
        cur_tag = "R1";
        req = 4'b1111;
        cyc(3);
        chk("R1", "grant in reset", int'(grant), 0);
        rst_n = 1'b1;
        req = 4'b0000;
        cyc(2);

        // R3 and R2: fixed priority, grant from idle
        cur_tag = "R3";
        req = 4'b1110; cyc(1);
        chk("R2", "grant after one edge", int'(grant), 2);
        cyc(2);
        // R5: higher request does not preempt
        cur_tag = "R5";
        req = 4'b1111; cyc(6);
        chk("R5", "no preempt", int'(grant), 2);
        // R10 / R3: release then lowest wins after one dead cycle
        cur_tag = "R10";
        req = 4'b1101; cyc(1);
        chk("R10", "dead cycle", int'(grant), 0);
        cyc(1);
        chk("R3", "lowest wins", int'(grant), 1);
        // R6: parking
        cur_tag = "R6";
        req = 4'b0000; cyc(5);
        chk("R6", "parked", int'(grant), 1);
        chk("R13", "owner while parked", int'(owner), 0);

        // R7: lock holds after owner drops
        cur_tag = "R7";
        lock = 1'b1; req = 4'b0110; cyc(6);
        chk("R7", "lock hold", int'(grant), 1);
        // R8: time-out overrides lock; R9 flag
        cur_tag = "R8";
        timeout_limit = 16'd4; cyc(8);
        lock = 1'b0; req = 4'b0000; timeout_limit = 16'd0; cyc(2);

        // R11: fixed mode time-out excludes revoked owner
        cur_tag = "R11";
        req = 4'b0001; cyc(2);
        req = 4'b1111; timeout_limit = 16'd3; cyc(20);
        // R8 boundary: limit 1 and limit 0
        cur_tag = "R8";
        timeout_limit = 16'd1; cyc(10);
        cur_tag = "R9";
        timeout_limit = 16'd2; cyc(10);
        cur_tag = "R8";
        timeout_limit = 16'd0; cyc(30);

        // R4: rotating with time-outs
        cur_tag = "R4";
        rotate_mode = 1'b1; timeout_limit = 16'd2; cyc(30);
        // R12: flip mode mid-ownership
        cur_tag = "R12";
        timeout_limit = 16'd0; req = 4'b1111; cyc(3);
        rotate_mode = 1'b0; cyc(3);
        rotate_mode = 1'b1; cyc(3);
        req = 4'b0111; cyc(6);

        // random mix
        for (int r = 0; r < 4000; r++) begin
            case (r % 4)
                0: cur_tag = "R2";
                1: cur_tag = "R13";
                2: cur_tag = "R4";
                default: cur_tag = "R9";
            endcase
            if ($urandom_range(0, 3) == 0) req = 4'($urandom_range(0, 15));
            if ($urandom_range(0, 7) == 0) lock = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 15) == 0) rotate_mode = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 31) == 0) timeout_limit = 16'($urandom_range(0, 6));
            cyc(1);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule